// File: doc/BRIEF.md
# Framed Serial Audio Transmitter

This block turns parallel words into a single serial data line. An external bit clock sets the timing and an external frame-sync pulse marks the start of each frame. Both arrive as plain inputs and are sampled with the block's system clock. On every selected edge of the bit clock the block drives the next bit, MSB first. An output-enable marks the bits that belong to a frame, so the line can be released between frames.

The block has two frame shapes. A single-phase frame carries 1 to 128 words that share one word length. A dual-phase frame carries exactly two words, left and right, and each has its own word length. Words enter through a valid/ready handshake, one word per slot. If no word is offered when a slot opens, the block sends zeros for that slot and raises a sticky underrun flag. The first data bit can follow the frame-sync pulse by 0, 1 or 2 bit clocks. Both the frame-sync active level and the driving edge of the bit clock are configurable.

Top module: `framed_ser_tx`

## Requirements
- R1: `cfg_len1`/`cfg_len2` codes 0,1,2,3,4,5 select word lengths 8,12,16,20,24,32 bits (codes 6 and 7 also give 32). A slot of length L sends `in_data[L-1:0]`, starting with bit L-1.
- R2: With `cfg_dual`=0, a frame carries `cfg_words`+1 words (1 to 128), all of length `cfg_len1`, sent back to back with no gap bit.
- R3: With `cfg_dual`=1, a frame carries exactly two words: the first with length `cfg_len1`, the second with length `cfg_len2`, back to back. `cfg_words` is then ignored.
- R4: Count the bit-clock drive edge on which the frame-sync start is seen as edge 0. The first data bit is then driven on drive edge `cfg_delay` (0, 1 or 2; the value 3 acts as 2).
- R5: A frame starts on a drive edge where frame-sync is at its active level (high when `cfg_fs_low`=0, low when 1) and was not active on the previous drive edge. A pulse held active over several edges starts only one frame.
- R6: `cfg_edge`=0 drives data on rising edges of `bclk` and `cfg_edge`=1 on falling edges. Outputs change within one system clock of that edge.
- R7: Outside the bits of a frame, `sd_oe` is 0 and `sd_out` is 0. `sd_oe` is 1 during every frame bit.
- R8: If `in_valid` is 0 when a slot opens, the slot carries all zeros and `underrun` goes to 1. It stays 1 until reset.
- R9: `in_ready` is high for one system clock at the opening of each slot. A word is consumed only in a cycle where both `in_ready` and `in_valid` are high.
- R10: A start with delay 0 during a running frame abandons that frame and starts the new one on the same edge. A start with delay 1 or 2 lets the running frame finish, so frames can follow each other with no gap.
- R11: After reset, `sd_out`, `sd_oe`, `underrun` and `in_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | External bit clock, synchronous to clk |
| fsync | input | 1 | External frame-sync |
| cfg_len1 | input | 3 | Word length code, phase 1 or single phase |
| cfg_len2 | input | 3 | Word length code, phase 2 |
| cfg_words | input | 7 | Words per single-phase frame minus one |
| cfg_dual | input | 1 | 1 selects two-phase frames |
| cfg_delay | input | 2 | Data delay in bit clocks after frame-sync |
| cfg_edge | input | 1 | 0 drives on rising bclk, 1 on falling |
| cfg_fs_low | input | 1 | 1 makes frame-sync active low |
| in_data | input | 32 | Word to send |
| in_valid | input | 1 | in_data holds a word |
| in_ready | output | 1 | Slot opening; word taken when valid |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Serial data enable |
| underrun | output | 1 | Sticky empty-slot flag |

## Verification
Every supported word length is sent in short single-phase frames. This shows whether the start of each word sits at the right bit and whether a word is truncated or padded. A 128-word frame checks the upper end of the word counter. Dual-phase frames use unequal lengths and overlapping start pulses, which separates the phase-2 length from the phase-1 length and shows gapless chaining. Three further groups of tests look at timing and control. The delay settings and an inverted pulse with a falling drive edge show off-by-one start errors and wrong-edge timing, and the long inverted pulse also tests edge detection against level detection. A starved input and a mid-frame restart show zero fill, the sticky flag and the abandon-and-restart rule.

// File: rtl/framed_ser_tx.sv
`timescale 1ns/1ps
module framed_ser_tx #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk,
  input  logic             fsync,
  input  logic [2:0]       cfg_len1,
  input  logic [2:0]       cfg_len2,
  input  logic [CNT_W-1:0] cfg_words,
  input  logic             cfg_dual,
  input  logic [1:0]       cfg_delay,
  input  logic             cfg_edge,
  input  logic             cfg_fs_low,
  input  logic [31:0]      in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             sd_out,
  output logic             sd_oe,
  output logic             underrun
);
  localparam int DW = 32;
  localparam int LW = 6;

  function automatic logic [LW-1:0] len_of(input logic [2:0] code);
    case (code)
      3'd0:    len_of = LW'(8);
      3'd1:    len_of = LW'(12);
      3'd2:    len_of = LW'(16);
      3'd3:    len_of = LW'(20);
      3'd4:    len_of = LW'(24);
      default: len_of = LW'(32);
    endcase
  endfunction

  logic             bclk_q, fs_prev;
  logic             waiting;
  logic [1:0]       wait_cnt;
  logic             active;
  logic [CNT_W-1:0] word_idx;
  logic [LW-1:0]    bits_left;
  logic [DW-1:0]    sh;

  logic             tick, fs_act, fs_start, start_now, last_word, next_slot, load;
  logic [1:0]       dly;
  logic [LW-1:0]    cur_len;
  logic [DW-1:0]    aligned;

  assign tick      = cfg_edge ? (bclk_q & ~bclk) : (~bclk_q & bclk);
  assign fs_act    = fsync ^ cfg_fs_low;
  assign fs_start  = tick & fs_act & ~fs_prev;
  assign dly       = (cfg_delay == 2'd3) ? 2'd2 : cfg_delay;
  assign start_now = tick & ((fs_start & (dly == 2'd0)) | (waiting & (wait_cnt == 2'd1)));
  assign last_word = cfg_dual ? (word_idx == CNT_W'(1)) : (word_idx == cfg_words);
  assign next_slot = tick & active & (bits_left == '0) & ~last_word;
  assign load      = start_now | next_slot;
  assign in_ready  = load;
  assign cur_len   = len_of((cfg_dual && !start_now) ? cfg_len2 : cfg_len1);
  assign aligned   = (in_valid ? in_data : '0) << (LW'(DW) - cur_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q    <= bclk;
      fs_prev   <= 1'b0;
      waiting   <= 1'b0;
      wait_cnt  <= '0;
      active    <= 1'b0;
      word_idx  <= '0;
      bits_left <= '0;
      sh        <= '0;
      sd_out    <= 1'b0;
      sd_oe     <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      bclk_q <= bclk;
      if (tick) begin
        fs_prev <= fs_act;
        if (fs_start && dly != 2'd0) begin
          waiting  <= 1'b1;
          wait_cnt <= dly;
        end else if (waiting) begin
          if (wait_cnt == 2'd1) waiting <= 1'b0;
          else                  wait_cnt <= wait_cnt - 2'd1;
        end

        if (load) begin
          sd_out    <= aligned[DW-1];
          sh        <= aligned << 1;
          bits_left <= cur_len - LW'(1);
          active    <= 1'b1;
          sd_oe     <= 1'b1;
          word_idx  <= start_now ? '0 : word_idx + CNT_W'(1);
          if (!in_valid) underrun <= 1'b1;
        end else if (active) begin
          if (bits_left != '0) begin
            sd_out    <= sh[DW-1];
            sh        <= sh << 1;
            bits_left <= bits_left - LW'(1);
          end else begin
            active <= 1'b0;
            sd_oe  <= 1'b0;
            sd_out <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/framed_ser_tx_chk.sv
`timescale 1ns/1ps
module framed_ser_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic sd_out,
  input logic sd_oe,
  input logic underrun
);
  a_r9_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);
  a_r9_ready_opens_slot: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> sd_oe);
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);
  a_r8_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(in_ready && !in_valid));
  a_r7_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_oe |-> !sd_out);
endmodule

bind framed_ser_tx framed_ser_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .sd_out(sd_out), .sd_oe(sd_oe), .underrun(underrun)
);

// File: tb/sim_framed_ser_tx.sv
`timescale 1ns/1ps
module sim_framed_ser_tx;
  logic clk = 0, rst_n = 0, bclk = 0, fsync = 0;
  logic [2:0] cfg_len1 = 0, cfg_len2 = 0;
  logic [6:0] cfg_words = 0;
  logic cfg_dual = 0, cfg_edge = 0, cfg_fs_low = 0;
  logic [1:0] cfg_delay = 0;
  logic [31:0] in_data;
  logic in_valid, in_ready, sd_out, sd_oe, underrun;

  logic [31:0] feed_mem [0:255];
  int feed_cnt = 0, feed_idx, rdy_cnt;
  logic exp_d [0:2047];
  logic exp_oe [0:2047];
  logic fsv [0:2047];
  int last_end;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign in_valid = (feed_idx < feed_cnt);
  assign in_data  = in_valid ? feed_mem[feed_idx[7:0]] : '0;

  always @(posedge clk)
    if (!rst_n) begin feed_idx <= 0; rdy_cnt <= 0; end
    else if (in_ready) begin
      rdy_cnt <= rdy_cnt + 1;
      if (in_valid) feed_idx <= feed_idx + 1;
    end

  framed_ser_tx u0 (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
    .cfg_len1(cfg_len1), .cfg_len2(cfg_len2), .cfg_words(cfg_words),
    .cfg_dual(cfg_dual), .cfg_delay(cfg_delay), .cfg_edge(cfg_edge),
    .cfg_fs_low(cfg_fs_low), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .sd_out(sd_out), .sd_oe(sd_oe), .underrun(underrun)
  );

  function automatic int lenv(input int code);
    case (code)
      0: return 8; 1: return 12; 2: return 16; 3: return 20; 4: return 24;
      default: return 32;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic setup(input bit edge_sel, input bit fs_low, input bit dual, input int c1, input int c2,
                       input int nw, input int dly, input int nfeed, input int seed);
    cfg_edge = edge_sel; cfg_fs_low = fs_low; cfg_dual = dual;
    cfg_len1 = 3'(c1); cfg_len2 = 3'(c2); cfg_words = 7'(nw - 1); cfg_delay = 2'(dly);
    for (int i = 0; i < 256; i++)
      feed_mem[i] = (32'(seed) * 32'h9E3779B9) ^ (32'(i) * 32'h6C8E9CF5) ^ 32'hA53C_96E1;
    feed_cnt = nfeed;
    for (int i = 0; i < 2048; i++) begin exp_d[i] = 0; exp_oe[i] = 0; fsv[i] = 0; end
    @(posedge clk); #1;
    rst_n = 0; bclk = edge_sel ? 1'b1 : 1'b0; fsync = fs_low;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (2) @(posedge clk);
  endtask

  task automatic add_frame(input int t0, input bit dual, input int c1, input int c2,
                           input int nw, input int dly, input int w0);
    int p, n;
    logic [31:0] word;
    p = t0 + dly;
    fsv[t0] = 1;
    n = dual ? 2 : nw;
    for (int w = 0; w < n; w++) begin
      int len;
      len = lenv((dual && w == 1) ? c2 : c1);
      word = (w0 + w < feed_cnt) ? feed_mem[w0 + w] : 32'h0;
      for (int b = len - 1; b >= 0; b--) begin
        exp_oe[p] = 1; exp_d[p] = word[b]; p++;
      end
    end
    last_end = p;
  endtask

  task automatic play(input int n, input string req);
    int errs = 0;
    for (int t = 0; t < n; t++) begin
      @(posedge clk); #1;
      bclk = cfg_edge ? 1'b0 : 1'b1;
      fsync = fsv[t] ^ cfg_fs_low;
      repeat (3) @(posedge clk);
      #1;
      if (sd_out !== exp_d[t] || sd_oe !== exp_oe[t]) begin
        if (errs == 0)
          $display("FAIL %s tick %0d: actual out=%b oe=%b expected out=%b oe=%b",
                   req, t, sd_out, sd_oe, exp_d[t], exp_oe[t]);
        errs++;
      end
      @(posedge clk); #1;
      bclk = cfg_edge ? 1'b1 : 1'b0;
      repeat (3) @(posedge clk);
    end
    total++;
    if (errs != 0) bad++;
  endtask

  task automatic t_reset;
    setup(0, 0, 0, 0, 0, 1, 0, 0, 1);
    #1;
    chk(sd_out == 0 && sd_oe == 0, "R11", "line after reset", {sd_out, sd_oe}, 0);
    chk(underrun == 0 && in_ready == 0, "R11", "flags after reset", {underrun, in_ready}, 0);
  endtask

  task automatic t_lengths;
    for (int c = 0; c < 6; c++) begin
      setup(0, 0, 0, c, 0, 3, 0, 3, 10 + c);
      add_frame(1, 0, c, 0, 3, 0, 0);
      play(last_end + 3, "R1 R2 R7");
      chk(feed_idx == 3, "R9", "words consumed", feed_idx, 3);
      chk(underrun == 0, "R8", "no underrun when fed", underrun, 0);
    end
  endtask

  task automatic t_max_words;
    setup(0, 0, 0, 0, 0, 128, 0, 128, 20);
    add_frame(0, 0, 0, 0, 128, 0, 0);
    play(last_end + 2, "R2");
    chk(rdy_cnt == 128, "R2", "slots in 128-word frame", rdy_cnt, 128);
  endtask

  task automatic t_dual;
    setup(0, 0, 1, 1, 2, 5, 1, 4, 30);
    add_frame(0, 1, 1, 2, 5, 1, 0);
    add_frame(last_end - 1, 1, 1, 2, 5, 1, 2);
    play(last_end + 3, "R3 R10");
    chk(rdy_cnt == 4, "R3", "slots in two stereo frames", rdy_cnt, 4);
    chk(underrun == 0, "R3", "no underrun", underrun, 0);
  endtask

  task automatic t_delays;
    for (int d = 0; d < 3; d++) begin
      setup(0, 0, 0, 2, 0, 2, d, 2, 40 + d);
      add_frame(1, 0, 2, 0, 2, d, 0);
      play(last_end + 2, "R4 R7");
    end
  endtask

  task automatic t_polarity;
    setup(1, 1, 0, 3, 0, 2, 1, 2, 50);
    add_frame(2, 0, 3, 0, 2, 1, 0);
    fsv[3] = 1; fsv[4] = 1;
    play(last_end + 3, "R5 R6");
    chk(rdy_cnt == 2, "R5", "one frame from long pulse", rdy_cnt, 2);
  endtask

  task automatic t_underrun;
    setup(0, 0, 0, 0, 0, 3, 0, 1, 60);
    add_frame(0, 0, 0, 0, 3, 0, 0);
    play(last_end + 2, "R8");
    chk(underrun == 1, "R8", "flag set", underrun, 1);
    chk(rdy_cnt == 3, "R9", "slot openings", rdy_cnt, 3);
    chk(feed_idx == 1, "R9", "words consumed", feed_idx, 1);
    repeat (50) @(posedge clk);
    #1 chk(underrun == 1, "R8", "flag sticky", underrun, 1);
  endtask

  task automatic t_abort;
    setup(0, 0, 0, 0, 0, 4, 0, 6, 70);
    add_frame(0, 0, 0, 0, 4, 0, 0);
    add_frame(10, 0, 0, 0, 4, 0, 2);
    play(last_end + 3, "R10");
    chk(rdy_cnt == 6, "R10", "slots after restart", rdy_cnt, 6);
  endtask

  initial begin
    t_reset;
    t_lengths;
    t_max_words;
    t_dual;
    t_delays;
    t_polarity;
    t_underrun;
    t_abort;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule